// File: doc/BRIEF.md
# Integer Data-Processing ALU with Condition Flags

This block is the combinational execute stage for register-to-register and register-to-immediate data-processing operations in a 32-bit integer pipeline. A 4-bit operation code selects one of sixteen operations: bitwise, add, subtract, reverse-subtract, carry-using variants, and four flag-only comparisons. The first operand comes from a register. The second operand arrives already shifted or rotated, because operand shifting is done upstream. The same holds for the carry that the shifter produces.

The block returns the 32-bit result and a destination write enable. It also returns the next negative, zero, carry and overflow flags, plus a flag-commit strobe. The incoming carry, and the overflow that the logical operations keep, are read from the current condition-code word. The caller commits the flags when the commit strobe is high. The block holds no state and needs no clock.

Top module: `dp_alu`

## Requirements
- R1: Codes 0x0 AND, 0x1 XOR, 0xC OR, 0xD MOVE (result = op_b), 0xE clear-bits (op_a AND NOT op_b) and 0xF MOVE-NOT (NOT op_b) give the bitwise results in `result`.
- R2: Code 0x4 gives op_a + op_b. Code 0x5 gives op_a + op_b + C, where C is bit 29 of `cc_word`.
- R3: Code 0x2 gives op_a − op_b and code 0x3 gives op_b − op_a. Code 0x6 gives op_a − op_b − (1 − C) and code 0x7 gives op_b − op_a − (1 − C), with C = `cc_word[29]`.
- R4: The test codes 0x8 (AND), 0x9 (XOR), 0xA (subtract) and 0xB (add) present their computed value on `result`. They hold `rd_we` low and drive `flags_we` high whatever `set_flags` is.
- R5: All other twelve codes drive `rd_we` high, and `flags_we` follows `set_flags`.
- R6: `flag_n` equals bit 31 of the computed value, and `flag_z` is high exactly when all 32 bits are zero.
- R7: For the add-type codes (0x4, 0x5, 0xB), `flag_c` is the carry out of bit 31. For the subtract-type codes (0x2, 0x3, 0x6, 0x7, 0xA), `flag_c` is 1 when no borrow occurs.
- R8: For the add-type and subtract-type codes, `flag_v` is high exactly when the two's-complement result overflows 32 bits.
- R9: For the bitwise codes (0x0, 0x1, 0x8, 0x9, 0xC to 0xF), `flag_c` equals `shift_carry` and `flag_v` equals `cc_word[28]`. For these codes the carry bit `cc_word[29]` does not affect any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 4 | Operation code |
| op_a | input | 32 | First operand (register) |
| op_b | input | 32 | Second operand, already shifted or rotated |
| cc_word | input | 32 | Current condition word; bit 29 carry, bit 28 overflow |
| shift_carry | input | 1 | Carry produced by the upstream shifter |
| set_flags | input | 1 | Caller asks for flag update |
| result | output | 32 | Computed value |
| rd_we | output | 1 | Destination register write enable |
| flag_n | output | 1 | Next negative flag |
| flag_z | output | 1 | Next zero flag |
| flag_c | output | 1 | Next carry flag |
| flag_v | output | 1 | Next overflow flag |
| flags_we | output | 1 | Commit the four flags |

## Verification
The assertions are checked whenever the inputs change. They cover these rules: the test codes never write the destination and always commit flags; MOVE forwards op_b; the bitwise codes take their carry from the shifter and keep the old overflow; an add of zero passes op_a through with carry and overflow clear. Whether the arithmetic is correct can be shown only by the bench scenarios. These compare every code against an independently written reference model across random operands. They also run directed carry-chain edges: all-ones plus one, signed-limit crossings, equal operands and zero minus one, each with the incoming carry both set and clear.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    localparam int unsigned DATA_W    = 32;
    localparam int unsigned OPC_W     = 4;
    localparam int unsigned CARRY_POS = 29;
    localparam int unsigned OVF_POS   = 28;

    typedef enum logic [OPC_W-1:0] {
        OPC_AND   = 4'h0,
        OPC_XOR   = 4'h1,
        OPC_SUB   = 4'h2,
        OPC_RSUB  = 4'h3,
        OPC_ADD   = 4'h4,
        OPC_ADDC  = 4'h5,
        OPC_SUBC  = 4'h6,
        OPC_RSUBC = 4'h7,
        OPC_TSTA  = 4'h8,
        OPC_TSTX  = 4'h9,
        OPC_CMPS  = 4'hA,
        OPC_CMPA  = 4'hB,
        OPC_OR    = 4'hC,
        OPC_MOVE  = 4'hD,
        OPC_CLR   = 4'hE,
        OPC_MOVN  = 4'hF
    } opcode_e;

    typedef enum logic {
        CLS_LOGIC = 1'b0,
        CLS_ARITH = 1'b1
    } op_class_e;

    typedef enum logic [2:0] {
        LOP_AND  = 3'd0,
        LOP_XOR  = 3'd1,
        LOP_OR   = 3'd2,
        LOP_CLR  = 3'd3,
        LOP_PASS = 3'd4,
        LOP_INV  = 3'd5
    } logic_op_e;

    typedef enum logic [1:0] {
        CIN_ZERO = 2'd0,
        CIN_ONE  = 2'd1,
        CIN_FLAG = 2'd2
    } carry_sel_e;

    typedef struct packed {
        op_class_e  cls;
        logic_op_e  lop;
        logic       swap;
        logic       inv_y;
        carry_sel_e cin_sel;
        logic       writes_rd;
    } alu_ctrl_t;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flag_set_t;

    function automatic logic pick_carry(carry_sel_e sel, logic cflag);
        case (sel)
            CIN_ONE:  return 1'b1;
            CIN_FLAG: return cflag;
            default:  return 1'b0;
        endcase
    endfunction

    function automatic alu_ctrl_t arith_ctrl(logic swap, logic inv_y,
                                             carry_sel_e cs, logic wr);
        alu_ctrl_t c;
        c.cls       = CLS_ARITH;
        c.lop       = LOP_AND;
        c.swap      = swap;
        c.inv_y     = inv_y;
        c.cin_sel   = cs;
        c.writes_rd = wr;
        return c;
    endfunction

    function automatic alu_ctrl_t logic_ctrl(logic_op_e op, logic wr);
        alu_ctrl_t c;
        c.cls       = CLS_LOGIC;
        c.lop       = op;
        c.swap      = 1'b0;
        c.inv_y     = 1'b0;
        c.cin_sel   = CIN_ZERO;
        c.writes_rd = wr;
        return c;
    endfunction

endpackage

// File: rtl/dp_alu_decode.sv
module dp_alu_decode
    import dp_alu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output alu_ctrl_t        ctrl
);

    always_comb begin
        case (opcode_e'(opcode))
            OPC_AND:   ctrl = logic_ctrl(LOP_AND,  1'b1);
            OPC_XOR:   ctrl = logic_ctrl(LOP_XOR,  1'b1);
            OPC_SUB:   ctrl = arith_ctrl(1'b0, 1'b1, CIN_ONE,  1'b1);
            OPC_RSUB:  ctrl = arith_ctrl(1'b1, 1'b1, CIN_ONE,  1'b1);
            OPC_ADD:   ctrl = arith_ctrl(1'b0, 1'b0, CIN_ZERO, 1'b1);
            OPC_ADDC:  ctrl = arith_ctrl(1'b0, 1'b0, CIN_FLAG, 1'b1);
            OPC_SUBC:  ctrl = arith_ctrl(1'b0, 1'b1, CIN_FLAG, 1'b1);
            OPC_RSUBC: ctrl = arith_ctrl(1'b1, 1'b1, CIN_FLAG, 1'b1);
            OPC_TSTA:  ctrl = logic_ctrl(LOP_AND,  1'b0);
            OPC_TSTX:  ctrl = logic_ctrl(LOP_XOR,  1'b0);
            OPC_CMPS:  ctrl = arith_ctrl(1'b0, 1'b1, CIN_ONE,  1'b0);
            OPC_CMPA:  ctrl = arith_ctrl(1'b0, 1'b0, CIN_ZERO, 1'b0);
            OPC_OR:    ctrl = logic_ctrl(LOP_OR,   1'b1);
            OPC_MOVE:  ctrl = logic_ctrl(LOP_PASS, 1'b1);
            OPC_CLR:   ctrl = logic_ctrl(LOP_CLR,  1'b1);
            default:   ctrl = logic_ctrl(LOP_INV,  1'b1);
        endcase
    end

endmodule

// File: rtl/dp_alu_adder.sv
module dp_alu_adder #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         swap,
    input  logic         inv_y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);

    localparam int unsigned MSB = W - 1;

    logic [W-1:0] x;
    logic [W-1:0] y;
    logic [W:0]   wide;

    always_comb begin
        x    = swap ? b : a;
        y    = swap ? a : b;
        y    = inv_y ? ~y : y;
        wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
        sum  = wide[W-1:0];
        cout = wide[W];
        ovf  = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
    end

    always_comb begin
        if (!$isunknown({a, b, swap, inv_y, cin})) begin
            // R7
            zero_add_chk: assert (!(!swap && !inv_y && !cin && b == '0) ||
                                  (sum == a && !cout && !ovf))
                else $error("adding zero must pass first operand unchanged");
        end
    end

endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
    import dp_alu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_op_e    lop,
    output logic [W-1:0] y
);

    always_comb begin
        case (lop)
            LOP_AND:  y = a & b;
            LOP_XOR:  y = a ^ b;
            LOP_OR:   y = a | b;
            LOP_CLR:  y = a & ~b;
            LOP_PASS: y = b;
            default:  y = ~b;
        endcase
    end

    always_comb begin
        if (!$isunknown({a, b, lop})) begin
            // R1
            move_pass_chk: assert (lop != LOP_PASS || y == b)
                else $error("move must forward second operand");
        end
    end

endmodule

// File: rtl/dp_alu_flags.sv
module dp_alu_flags
    import dp_alu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] value,
    input  op_class_e    cls,
    input  logic         add_cout,
    input  logic         add_ovf,
    input  logic         shift_carry,
    input  logic         v_prev,
    output flag_set_t    flags
);

    always_comb begin
        flags.n = value[W-1];
        flags.z = (value == '0);
        if (cls == CLS_ARITH) begin
            flags.c = add_cout;
            flags.v = add_ovf;
        end else begin
            flags.c = shift_carry;
            flags.v = v_prev;
        end
    end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_alu_pkg::*;
(
    input  logic [3:0]  opcode,
    input  logic [31:0] op_a,
    input  logic [31:0] op_b,
    input  logic [31:0] cc_word,
    input  logic        shift_carry,
    input  logic        set_flags,
    output logic [31:0] result,
    output logic        rd_we,
    output logic        flag_n,
    output logic        flag_z,
    output logic        flag_c,
    output logic        flag_v,
    output logic        flags_we
);

    alu_ctrl_t         ctrl;
    flag_set_t         flags;
    logic [DATA_W-1:0] arith_y;
    logic [DATA_W-1:0] logic_y;
    logic              add_cout;
    logic              add_ovf;
    logic              cin;
    logic [DATA_W-3:0] cc_unused;

    assign cc_unused = {cc_word[31:30], cc_word[27:0]};

    dp_alu_decode u_decode (
        .opcode (opcode),
        .ctrl   (ctrl)
    );

    assign cin = pick_carry(ctrl.cin_sel, cc_word[CARRY_POS]);

    dp_alu_adder #(.W(DATA_W)) u_adder (
        .a     (op_a),
        .b     (op_b),
        .swap  (ctrl.swap),
        .inv_y (ctrl.inv_y),
        .cin   (cin),
        .sum   (arith_y),
        .cout  (add_cout),
        .ovf   (add_ovf)
    );

    dp_alu_logic #(.W(DATA_W)) u_logic (
        .a   (op_a),
        .b   (op_b),
        .lop (ctrl.lop),
        .y   (logic_y)
    );

    assign result = (ctrl.cls == CLS_ARITH) ? arith_y : logic_y;

    dp_alu_flags #(.W(DATA_W)) u_flags (
        .value       (result),
        .cls         (ctrl.cls),
        .add_cout    (add_cout),
        .add_ovf     (add_ovf),
        .shift_carry (shift_carry),
        .v_prev      (cc_word[OVF_POS]),
        .flags       (flags)
    );

    assign flag_n   = flags.n;
    assign flag_z   = flags.z;
    assign flag_c   = flags.c;
    assign flag_v   = flags.v;
    assign rd_we    = ctrl.writes_rd;
    assign flags_we = set_flags | ~ctrl.writes_rd;

    always_comb begin
        if (!$isunknown({opcode, set_flags, shift_carry, cc_word[OVF_POS]})) begin
            // R4
            test_no_write_chk: assert (!(opcode[3:2] == 2'b10) || (!rd_we && flags_we))
                else $error("test code wrote destination or skipped flags");
            // R5
            plain_flag_follow_chk: assert ((opcode[3:2] == 2'b10) || (flags_we == set_flags))
                else $error("flag commit does not follow request");
            // R9
            logic_flag_src_chk: assert (ctrl.cls != CLS_LOGIC ||
                                        (flag_c == shift_carry && flag_v == cc_word[OVF_POS]))
                else $error("bitwise code flag sources wrong");
        end
    end

endmodule

// File: tb/dp_alu_bench.sv
module dp_alu_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic [3:0]  opcode = '0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [31:0] cc_word = '0;
    logic        shift_carry = 1'b0;
    logic        set_flags = 1'b0;
    logic [31:0] result;
    logic        rd_we, flag_n, flag_z, flag_c, flag_v, flags_we;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dp_alu u_dp_alu (
        .opcode      (opcode),
        .op_a        (op_a),
        .op_b        (op_b),
        .cc_word     (cc_word),
        .shift_carry (shift_carry),
        .set_flags   (set_flags),
        .result      (result),
        .rd_we       (rd_we),
        .flag_n      (flag_n),
        .flag_z      (flag_z),
        .flag_c      (flag_c),
        .flag_v      (flag_v),
        .flags_we    (flags_we)
    );

    task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s op=%h a=%h b=%h cc=%h actual=%h expected=%h",
                     req, what, opcode, op_a, op_b, cc_word, got, exp);
        end
    endtask

    function automatic bit is_arith(logic [3:0] op);
        return (op >= 4'h2 && op <= 4'h7) || op == 4'hA || op == 4'hB;
    endfunction

    function automatic string res_req(logic [3:0] op);
        if (op[3:2] == 2'b10) return "R4";
        if (op == 4'h4 || op == 4'h5) return "R2";
        if (is_arith(op)) return "R3";
        return "R1";
    endfunction

    task automatic apply_check(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                               logic [31:0] cc, logic sc, logic sf);
        logic [31:0] er;
        logic ec, ev, c_in;
        longint sa, sb, s;
        longint unsigned ua, ub, u;
        opcode = op; op_a = a; op_b = b; cc_word = cc;
        shift_carry = sc; set_flags = sf;
        @(negedge clk);
        c_in = cc[29];
        ua = longint'(a); ub = longint'(b);
        sa = longint'($signed(a)); sb = longint'($signed(b));
        ec = sc; ev = cc[28];
        er = '0;
        case (op)
            4'h0, 4'h8: er = a & b;
            4'h1, 4'h9: er = a ^ b;
            4'hC: er = a | b;
            4'hD: er = b;
            4'hE: er = a & ~b;
            4'hF: er = ~b;
            4'h4, 4'hB, 4'h5: begin
                u = ua + ub + ((op == 4'h5) ? longint'(c_in) : 0);
                s = sa + sb + ((op == 4'h5) ? longint'(c_in) : 0);
                er = u[31:0]; ec = u[32];
                ev = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            end
            default: begin
                longint unsigned minu, subu;
                longint mins, subs, bor;
                bor = (op == 4'h6 || op == 4'h7) ? longint'(!c_in) : 0;
                if (op == 4'h3 || op == 4'h7) begin
                    minu = ub; subu = ua; mins = sb; subs = sa;
                end else begin
                    minu = ua; subu = ub; mins = sa; subs = sb;
                end
                u  = minu - subu - longint'(bor);
                s  = mins - subs - bor;
                er = u[31:0];
                ec = (minu >= subu + longint'(bor));
                ev = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            end
        endcase
        check(res_req(op), "result", result, er);
        check(op[3:2] == 2'b10 ? "R4" : "R5", "rd_we", {31'b0, rd_we}, {31'b0, op[3:2] != 2'b10});
        check(op[3:2] == 2'b10 ? "R4" : "R5", "flags_we", {31'b0, flags_we},
              {31'b0, sf | (op[3:2] == 2'b10)});
        check("R6", "flag_n", {31'b0, flag_n}, {31'b0, er[31]});
        check("R6", "flag_z", {31'b0, flag_z}, {31'b0, er == 32'h0});
        check(is_arith(op) ? "R7" : "R9", "flag_c", {31'b0, flag_c}, {31'b0, ec});
        check(is_arith(op) ? "R8" : "R9", "flag_v", {31'b0, flag_v}, {31'b0, ev});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired before completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    localparam logic [31:0] C_SET = 32'h2000_0000;
    localparam logic [31:0] V_SET = 32'h1000_0000;

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        // R1 reset-like idle: AND of zeros gives zero, Z set
        apply_check(4'h0, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0);
        // R2 R7 R8 carry chain edges
        apply_check(4'h4, 32'hFFFF_FFFF, 32'h1, 32'h0, 1'b0, 1'b1);
        apply_check(4'h4, 32'h7FFF_FFFF, 32'h1, 32'h0, 1'b0, 1'b1);
        apply_check(4'h5, 32'hFFFF_FFFF, 32'h0, C_SET, 1'b0, 1'b1);
        apply_check(4'h5, 32'h7FFF_FFFF, 32'h0, C_SET, 1'b0, 1'b0);
        apply_check(4'h5, 32'h8000_0000, 32'h8000_0000, 32'h0, 1'b0, 1'b1);
        // R3 R7 subtract borrow edges
        apply_check(4'h2, 32'h5, 32'h5, 32'h0, 1'b0, 1'b1);
        apply_check(4'h2, 32'h0, 32'h1, C_SET, 1'b0, 1'b1);
        apply_check(4'h2, 32'h8000_0000, 32'h1, 32'h0, 1'b0, 1'b1);
        apply_check(4'h3, 32'h1, 32'h0, 32'h0, 1'b0, 1'b1);
        apply_check(4'h6, 32'h5, 32'h5, 32'h0, 1'b0, 1'b1);
        apply_check(4'h6, 32'h5, 32'h5, C_SET, 1'b0, 1'b1);
        apply_check(4'h7, 32'h3, 32'h3, 32'h0, 1'b0, 1'b1);
        apply_check(4'h7, 32'h3, 32'h0, C_SET, 1'b0, 1'b0);
        // R4 test codes with set_flags low
        apply_check(4'hA, 32'h10, 32'h10, 32'h0, 1'b0, 1'b0);
        apply_check(4'hB, 32'hFFFF_FFFF, 32'h1, 32'h0, 1'b1, 1'b0);
        apply_check(4'h8, 32'hF0, 32'h0F, V_SET, 1'b1, 1'b0);
        apply_check(4'h9, 32'hAA, 32'hAA, 32'h0, 1'b0, 1'b0);
        // R9 carry bit ignored by bitwise codes, overflow kept
        apply_check(4'hD, 32'h0, 32'h8000_0000, C_SET | V_SET, 1'b0, 1'b1);
        apply_check(4'hF, 32'h0, 32'hFFFF_FFFF, C_SET, 1'b1, 1'b1);
        apply_check(4'hE, 32'hFFFF_FFFF, 32'h0F0F_0F0F, V_SET, 1'b0, 1'b1);
        apply_check(4'hC, 32'h1, 32'h2, 32'h0, 1'b1, 1'b0);
        // random sweep over all codes
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] ra, rb, rc;
            logic [3:0] rop;
            rop = 4'($urandom_range(0, 15));
            ra  = $urandom();
            rb  = $urandom();
            rc  = $urandom();
            if (i % 7 == 0) rb = ra;
            if (i % 11 == 0) ra = 32'hFFFF_FFFF;
            apply_check(rop, ra, rb, rc, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule